// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Transmit-End Flag

This block serialises characters onto a single line for an asynchronous link. A base-clock enable pulse arrives at sixteen times the bit rate. Every bit on the line lasts sixteen of those pulses. A character is written into a one-entry holding register through a valid/ready handshake. When transmission is enabled, the character is moved into the shifter and sent. The frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line rests high.

A transmit-end flag goes high as soon as the stop phase of a character begins, provided no further character is waiting. Software can therefore learn early that the line is about to go quiet. A character written before the stop phase ends follows without any idle gap, and the flag stays low. The enable can cut a frame short during its start, data or parity bits. Once the stop phase has begun, a disable is only acted on after a guard interval. The guard is half a bit time for one stop bit and one and a half bit times for two, so an early disable cannot clip the stop level. Format settings are captured when a frame starts.

Top module: `sertx`

## Requirements
- R1: After reset, and whenever nothing is being sent, `txd` is 1 and `din_ready` is 1. The end flag `tx_end` resets to 1.
- R2: Every bit lasts exactly 16 `tick` pulses. `txd` changes only on the clock edge of a `tick` pulse, except when a frame is aborted.
- R3: A frame is a start bit of 0, then the data bits starting with bit 0, then the parity bit if one is enabled, then stop bits of 1. A frame is 9 to 12 bits long.
- R4: With `cfg_short`=1 only `din[6:0]` is sent and `din[7]` is ignored. With `cfg_short`=0 all 8 bits are sent.
- R5: `cfg_par` selects parity: 2'b01 is even and 2'b10 is odd. 2'b00 and 2'b11 send no parity bit. With even parity, the parity bit makes the count of ones over the sent data bits plus the parity bit even. With odd parity, it makes that count odd.
- R6: `cfg_two_stop`=1 sends two stop bits. `cfg_two_stop`=0 sends one.
- R7: The holding register holds one character. `din_ready` is the inverse of its occupancy. A write is taken on a clock edge with `din_valid` and `din_ready` both high. A write offered while `din_ready` is 0 is not taken. The register empties on the tick edge that starts the character's frame.
- R8: `tx_end` rises on the tick edge that enters the first stop bit when no character is waiting. The line is then high. `tx_end` stays 1 until the next write.
- R9: `tx_end` is 0 in the cycle after a write is taken.
- R10: A character waiting when the last stop bit ends starts on that same tick edge, with no idle gap. `tx_end` stays 0 for the earlier frame.
- R11: Dropping `tx_en` during a start, data or parity bit returns the line to 1 on the next clock. The character in progress is discarded and is not resent.
- R12: During the stop phase, a low `tx_en` is acted on only once 8 ticks (one stop bit) or 24 ticks (two stop bits) have passed since the stop phase began. If `tx_en` returns high before that, the frame finishes unchanged. If `tx_en` is still low after the guard, the transmitter goes idle. It can then start a waiting character on the next tick after `tx_en` rises again.
- R13: No frame starts while `tx_en` is 0. A written character is kept until `tx_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Base-clock enable, one pulse per sixteenth of a bit |
| tx_en | input | 1 | Transmit enable |
| cfg_short | input | 1 | 1: seven data bits, 0: eight |
| cfg_par | input | 2 | Parity mode: 01 even, 10 odd, 00/11 none |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| din | input | DATA_W | Character to send |
| din_valid | input | 1 | Write request |
| din_ready | output | 1 | Holding register is empty |
| txd | output | 1 | Serial line, idles high |
| tx_end | output | 1 | Transmit-end flag |

## Verification
The line changes one clock after the tick edge that causes it. An abort raises the line one clock after `tx_en` is seen low. `din_ready` and `tx_end` respond one clock after a write. The bench keeps its own running count of tick edges. It fixes the frame origin at the tick edge where the start bit appears, and samples each bit eight ticks into its sixteen-tick window. The guard and back-to-back cases are sampled at exact tick offsets from the first stop bit, where a missing guard or an idle gap would move the next start bit.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  // Parity selector encodings.
  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  // Bit sequencer phases.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } sertx_state_e;

endpackage

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
// One-entry holding register between the write port and the shifter.
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              wr_accept,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign wr_ready  = !full_q;
  assign wr_accept = wr_valid && !full_q;
  assign full      = full_q;
  assign data      = data_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (pop) full_d = 1'b0;
    if (wr_accept) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/sertx_seq.sv
`timescale 1ns/1ps
// Frame sequencer: start, data, parity, stop phases with stop-phase guard.
// OVERSAMPLE must be a power of two (the stop-phase elapsed count is {second_stop, sub}).
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              cfg_short,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              pop,
  output logic              stop_entry,
  output logic              txd
);

  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int EL_W  = SUB_W + 1;
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OVERSAMPLE - 1);
  localparam logic [EL_W-1:0]  GUARD_ONE = EL_W'(OVERSAMPLE / 2);
  localparam logic [EL_W-1:0]  GUARD_TWO = EL_W'(OVERSAMPLE + OVERSAMPLE / 2);

  sertx_state_e      state_q, state_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              pbit_q, pbit_d;
  logic              short_q, short_d;
  logic              two_q, two_d;
  logic              paren_q, paren_d;
  logic              stophi_q, stophi_d;

  logic              load, bit_end, start_ok;
  logic [SUB_W-1:0]  sub_inc;
  logic [EL_W-1:0]   elapsed, guard;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] masked;
  logic              load_pbit;

  // Parity of the character about to be loaded.
  always_comb begin
    masked = hold_data;
    if (cfg_short) masked[DATA_W-1] = 1'b0;
    load_pbit = (^masked) ^ (cfg_par == PAR_ODD);
  end

  assign sub_inc  = sub_q + 1'b1;
  assign bit_end  = tick && (sub_q == SUB_LAST);
  assign start_ok = tick && tx_en && hold_full;
  assign elapsed  = {stophi_q, sub_q};
  assign guard    = two_q ? GUARD_TWO : GUARD_ONE;
  assign last_idx = short_q ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);

  always_comb begin
    state_d    = state_q;
    sub_d      = sub_q;
    idx_d      = idx_q;
    shreg_d    = shreg_q;
    pbit_d     = pbit_q;
    short_d    = short_q;
    two_d      = two_q;
    paren_d    = paren_q;
    stophi_d   = stophi_q;
    load       = 1'b0;
    stop_entry = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) load = 1'b1;
      end
      ST_START, ST_DATA, ST_PAR: begin
        if (!tx_en) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          sub_d = sub_inc;
          if (bit_end) begin
            if (state_q == ST_START) begin
              state_d = ST_DATA;
              idx_d   = '0;
            end else if (state_q == ST_DATA && idx_q != last_idx) begin
              idx_d   = idx_q + 1'b1;
              shreg_d = shreg_q >> 1;
            end else if (state_q == ST_DATA && paren_q) begin
              state_d = ST_PAR;
            end else begin
              state_d    = ST_STOP;
              stophi_d   = 1'b0;
              stop_entry = 1'b1;
            end
          end
        end
      end
      ST_STOP: begin
        if (!tx_en && elapsed >= guard) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          sub_d = sub_inc;
          if (bit_end) begin
            if (two_q && !stophi_q) stophi_d = 1'b1;
            else if (start_ok)      load     = 1'b1;
            else                    state_d  = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) begin
      state_d  = ST_START;
      sub_d    = '0;
      idx_d    = '0;
      shreg_d  = hold_data;
      pbit_d   = load_pbit;
      short_d  = cfg_short;
      two_d    = cfg_two_stop;
      paren_d  = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
      stophi_d = 1'b0;
    end
  end

  assign pop = load;

  always_comb begin
    unique case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg_q[0];
      ST_PAR:   txd = pbit_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sub_q    <= '0;
      idx_q    <= '0;
      shreg_q  <= '0;
      pbit_q   <= 1'b0;
      short_q  <= 1'b0;
      two_q    <= 1'b0;
      paren_q  <= 1'b0;
      stophi_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sub_q    <= sub_d;
      idx_q    <= idx_d;
      shreg_q  <= shreg_d;
      pbit_q   <= pbit_d;
      short_q  <= short_d;
      two_q    <= two_d;
      paren_q  <= paren_d;
      stophi_q <= stophi_d;
    end
  end

endmodule

// File: rtl/sertx_flag.sv
`timescale 1ns/1ps
// Transmit-end flag: set on stop-phase entry with nothing waiting, cleared by a write.
module sertx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_accept,
  input  logic stop_entry,
  input  logic hold_full,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (stop_entry && !hold_full) flag_d = 1'b1;
    if (wr_accept)                flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/sertx.sv
`timescale 1ns/1ps
module sertx #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              cfg_short,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  output logic              din_ready,
  output logic              txd,
  output logic              tx_end
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_accept, pop, stop_entry, hold_full;
  logic [DATA_W-1:0] hold_data;

  // Reset asserts immediately, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_valid  (din_valid),
    .wr_ready  (din_ready),
    .wr_accept (wr_accept),
    .wr_data   (din),
    .pop       (pop),
    .full      (hold_full),
    .data      (hold_data)
  );

  sertx_seq #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tick         (tick),
    .tx_en        (tx_en),
    .cfg_short    (cfg_short),
    .cfg_par      (cfg_par),
    .cfg_two_stop (cfg_two_stop),
    .hold_full    (hold_full),
    .hold_data    (hold_data),
    .pop          (pop),
    .stop_entry   (stop_entry),
    .txd          (txd)
  );

  sertx_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_accept  (wr_accept),
    .stop_entry (stop_entry),
    .hold_full  (hold_full),
    .flag       (tx_end)
  );

endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_en,
  input logic din_valid,
  input logic din_ready,
  input logic txd,
  input logic tx_end
);

  // R7: a taken write fills the single entry
  p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=> !din_ready);

  // R9: a taken write clears the end flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=> !tx_end);

  // R8: the end flag rises only while the line is at the stop level
  p_flag_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> txd);

  // R2: a falling line edge is always caused by a tick edge
  p_fall_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(tick));

  // R11: one clock after the enable is seen low the line is high
  p_abort_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tx_en) |-> txd);

endmodule

bind sertx sertx_chk u_chk (.*);

// File: tb/sertx_test.sv
`timescale 1ns/1ps
module sertx_test;

  localparam real CLK_NS = 4.0;

  typedef struct packed {
    logic [7:0] data;
    logic       short_len;
    logic [1:0] par;
    logic       two;
    logic [3:0] len;
    logic       pbit;
  } vec_t;

  // data, 7-bit, parity mode, two stop, expected frame length, expected parity bit
  localparam vec_t VECS [9] = '{
    '{8'h55, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0},
    '{8'hA3, 1'b0, 2'd1, 1'b0, 4'd11, 1'b0},
    '{8'hA3, 1'b0, 2'd2, 1'b1, 4'd12, 1'b1},
    '{8'h7F, 1'b1, 2'd0, 1'b0, 4'd9,  1'b0},
    '{8'hFF, 1'b1, 2'd1, 1'b1, 4'd11, 1'b1},
    '{8'h01, 1'b1, 2'd2, 1'b0, 4'd10, 1'b0},
    '{8'h00, 1'b0, 2'd2, 1'b0, 4'd11, 1'b1},
    '{8'h80, 1'b1, 2'd1, 1'b0, 4'd10, 1'b0},
    '{8'hC4, 1'b0, 2'd3, 1'b0, 4'd10, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick = 1'b0;
  logic       tx_en;
  logic       cfg_short;
  logic [1:0] cfg_par;
  logic       cfg_two_stop;
  logic [7:0] din;
  logic       din_valid;
  logic       din_ready;
  logic       txd;
  logic       tx_end;

  int checks = 0;
  int fails  = 0;
  int tcount = 0;

  sertx uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .tx_en        (tx_en),
    .cfg_short    (cfg_short),
    .cfg_par      (cfg_par),
    .cfg_two_stop (cfg_two_stop),
    .din          (din),
    .din_valid    (din_valid),
    .din_ready    (din_ready),
    .txd          (txd),
    .tx_end       (tx_end)
  );

  always #(CLK_NS / 2.0) clk = ~clk;

  // Tick every second clock, with a running count of tick edges.
  always @(posedge clk) begin
    tick <= ~tick;
    if (tick) tcount <= tcount + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (tcount < t) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    din       = d;
    din_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    din_valid = 1'b0;
    check("R9", "flag after write", int'(tx_end), 0);
  endtask

  task automatic find_start(output int t0);
    int n = 0;
    while (txd !== 1'b0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) check("R3", "start bit seen", 0, 1);
    t0 = tcount;
  endtask

  // Samples every bit mid-window; t0 is the tick edge that began the start bit.
  task automatic check_frame(input vec_t v, input int t0, input bit queued);
    int  n  = v.short_len ? 7 : 8;
    bit  pe = (v.par == 2'd1) || (v.par == 2'd2);
    int  fs = 1 + n + (pe ? 1 : 0);
    for (int i = 0; i < int'(v.len); i++) begin
      int    exp;
      string tag;
      wait_until(t0 + 8 + 16 * i);
      if (i == 0) begin
        exp = 0; tag = "R3";
      end else if (i <= n) begin
        exp = int'(v.data[i-1]); tag = v.short_len ? "R4" : "R3";
      end else if (pe && i == n + 1) begin
        exp = int'(v.pbit); tag = "R5";
      end else begin
        exp = 1; tag = v.two ? "R6" : "R3";
      end
      check(tag, $sformatf("bit %0d of %02h", i, v.data), int'(txd), exp);
      if (i == fs - 1) check("R8", "flag before stop", int'(tx_end), 0);
      if (i == fs) check(queued ? "R10" : "R8", "flag in stop", int'(tx_end), queued ? 0 : 1);
    end
  endtask

  task automatic idle_after(input int t0, input int len);
    wait_until(t0 + 16 * len + 16);
    check("R1", "line idle after frame", int'(txd), 1);
    check("R1", "ready idle after frame", int'(din_ready), 1);
  endtask

  // Watchdog
  initial begin
    #(CLK_NS * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t0;
    vec_t a, b;
    rst_n = 1'b0; tx_en = 1'b0; cfg_short = 1'b0; cfg_par = 2'd0; cfg_two_stop = 1'b0;
    din = '0; din_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "txd in reset", int'(txd), 1);
    check("R1", "ready in reset", int'(din_ready), 1);
    check("R1", "flag in reset", int'(tx_end), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "txd after reset", int'(txd), 1);
    check("R1", "flag after reset", int'(tx_end), 1);

    // Table of frames
    foreach (VECS[k]) begin
      cfg_short = VECS[k].short_len; cfg_par = VECS[k].par; cfg_two_stop = VECS[k].two;
      tx_en = 1'b1;
      write(VECS[k].data);
      find_start(t0);
      check_frame(VECS[k], t0, 1'b0);
      idle_after(t0, int'(VECS[k].len));
      check("R8", "flag held while idle", int'(tx_end), 1);
    end

    // R13 / R7: held while disabled, second write refused
    cfg_short = 1'b0; cfg_par = 2'd0; cfg_two_stop = 1'b0;
    tx_en = 1'b0;
    write(8'h96);
    check("R7", "ready after write", int'(din_ready), 0);
    wait_until(tcount + 40);
    check("R13", "no frame while disabled", int'(txd), 1);
    din = 8'h3C; din_valid = 1'b1;
    repeat (4) @(negedge clk);
    din_valid = 1'b0;
    check("R7", "still full", int'(din_ready), 0);
    tx_en = 1'b1;
    find_start(t0);
    check("R7", "ready at frame start", int'(din_ready), 1);
    a = '{8'h96, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    check_frame(a, t0, 1'b0);
    wait_until(t0 + 160 + 32);
    check("R7", "refused write not sent", int'(txd), 1);

    // R2: bit window boundaries
    write(8'h0F);
    find_start(t0);
    wait_until(t0 + 15);
    check("R2", "start bit at tick 15", int'(txd), 0);
    wait_until(t0 + 16);
    check("R2", "bit 0 at tick 16", int'(txd), 1);
    wait_until(t0 + 31);
    check("R2", "bit 0 at tick 31", int'(txd), 1);
    idle_after(t0, 10);

    // R10: back to back
    a = '{8'h5A, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    b = '{8'hC3, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    write(a.data);
    find_start(t0);
    check("R7", "ready once shifted", int'(din_ready), 1);
    write(b.data);
    check("R7", "ready with queued", int'(din_ready), 0);
    check_frame(a, t0, 1'b1);
    wait_until(t0 + 160);
    check("R10", "next start without gap", int'(txd), 0);
    check_frame(b, t0 + 160, 1'b0);
    idle_after(t0 + 160, 10);

    // R12: disable inside guard, one stop bit
    a = '{8'h12, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    b = '{8'h34, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    write(a.data);
    find_start(t0);
    write(b.data);
    wait_until(t0 + 144);
    tx_en = 1'b0;
    wait_until(t0 + 148);
    tx_en = 1'b1;
    wait_until(t0 + 154);
    check("R12", "stop kept, one stop", int'(txd), 1);
    wait_until(t0 + 160);
    check("R12", "next start on time, one stop", int'(txd), 0);
    check_frame(b, t0 + 160, 1'b0);
    idle_after(t0 + 160, 10);

    // R12: disable inside guard, two stop bits
    cfg_two_stop = 1'b1;
    a = '{8'hE1, 1'b0, 2'd0, 1'b1, 4'd11, 1'b0};
    b = '{8'h1E, 1'b0, 2'd0, 1'b1, 4'd11, 1'b0};
    write(a.data);
    find_start(t0);
    write(b.data);
    wait_until(t0 + 144);
    tx_en = 1'b0;
    wait_until(t0 + 164);
    tx_en = 1'b1;
    wait_until(t0 + 174);
    check("R12", "stop kept, two stop", int'(txd), 1);
    wait_until(t0 + 176);
    check("R12", "next start on time, two stop", int'(txd), 0);
    check_frame(b, t0 + 176, 1'b0);
    idle_after(t0 + 176, 11);

    // R12: disable beyond guard, one stop bit
    cfg_two_stop = 1'b0;
    a = '{8'h99, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    b = '{8'h66, 1'b0, 2'd0, 1'b0, 4'd10, 1'b0};
    write(a.data);
    find_start(t0);
    write(b.data);
    wait_until(t0 + 144);
    tx_en = 1'b0;
    wait_until(t0 + 156);
    check("R12", "line high after guard", int'(txd), 1);
    tx_en = 1'b1;
    wait_until(t0 + 157);
    check("R12", "restart after abandoned stop", int'(txd), 0);
    check_frame(b, t0 + 157, 1'b0);
    idle_after(t0 + 157, 10);

    // R11: abort during data
    write(8'h00);
    find_start(t0);
    wait_until(t0 + 40);
    check("R3", "data bit 1 low", int'(txd), 0);
    tx_en = 1'b0;
    @(negedge clk);
    check("R11", "line high after abort", int'(txd), 1);
    wait_until(t0 + 100);
    check("R11", "line high while disabled", int'(txd), 1);
    check("R11", "nothing pending", int'(din_ready), 1);
    tx_en = 1'b1;
    wait_until(t0 + 160);
    check("R11", "aborted char not resent", int'(txd), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule